// File: doc/BRIEF.md
# Serial Audio Link Downstream Frame Receiver

This block sits on the codec side of a bit-serial audio link. It watches a frame-start line and a serial data line, both clocked by the link bit clock, and rebuilds each 256-bit downstream frame. A frame holds a 16-bit tag followed by twelve 20-bit slots. The block checks that every frame is the full length. It reads the tag, and it hands the command address, the command data and a left/right pair of PCM samples to the codec core. Each of these four items comes with a single-cycle valid strobe.

A 2-bit strap selects the role of the codec. The value 0 makes it the primary codec, which takes slots 1 to 4 under the control of their own tag valid bits. Any other value makes it secondary codec 1, 2 or 3. A secondary codec accepts a frame only when the codec-ID field of the tag equals the strap value, and it takes its audio from a slot pair that depends on that value. The link cannot be stalled, so the outputs have no ready input and no back-pressure: each strobe is a one-cycle valid that the consumer must take in that cycle. The data outputs hold their last accepted value between strobes.

Top module: `aclink_rx`

## Requirements
- R1: While reset is asserted and after it is released, all four valid strobes are 0 and all four data outputs are 0 until the first accepted frame.
- R2: The frame-start line is sampled on the rising clock edge, and a 0-to-1 change starts a frame. The serial bit launched after that edge is sampled on the next falling edge and is tag bit 15. The remaining bits follow MSB first: 16 tag bits (15 down to 0), then slots 1 to 12 of 20 bits each, every slot MSB first.
- R3: Strobes rise only on the rising edge that consumes bit 255 of a complete frame. Each strobe lasts exactly one cycle. A data output changes only when its strobe is asserted.
- R4: A frame-start edge that arrives before 256 bits of the current frame have been consumed cancels that frame, which produces no strobes. The frame that the early edge announces is also ignored. Reception resumes at the next frame-start edge.
- R5: When tag bit 15 (frame valid) is 0, the frame produces no strobes, whatever the other tag bits hold.
- R6: In primary mode (strap 00), slot s is accepted only when tag bit 15-s is 1. Slot 1 drives the command address, slot 2 the command data, slot 3 the left PCM output and slot 4 the right PCM output. Tag bits 1:0 are ignored in this mode.
- R7: In a secondary mode (strap 01, 10 or 11), a frame whose tag bits 1:0 (ID1 above ID0) differ from the strap produces no strobes.
- R8: In a secondary mode with a matching ID, the command address (slot 1) and command data (slot 2) are both accepted, whatever the values of tag bits 14 and 13.
- R9: In a secondary mode with a matching ID, the left/right PCM come from slots 3/4 (strap 01), 7/8 (strap 10) or 6/9 (strap 11). Each one is accepted only when its slot's tag bit 15-s is 1.
- R10: Frames sent back to back, where the next start edge is sampled on the same rising edge that consumes bit 255, are all accepted.
- R11: The strap is sampled when a frame starts. A change of the strap during a frame has no effect on how that frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_sync | input | 1 | Frame-start line, sampled on the rising edge |
| frm_sdata | input | 1 | Serial downstream data, sampled on the falling edge |
| mode_strap | input | 2 | Codec role: 00 primary, 01/10/11 secondary 1/2/3 |
| cmd_addr_vld | output | 1 | Command address strobe |
| cmd_addr | output | 20 | Slot 1 contents |
| cmd_data_vld | output | 1 | Command data strobe |
| cmd_data | output | 20 | Slot 2 contents |
| pcm_l_vld | output | 1 | Left PCM strobe |
| pcm_l | output | 20 | Left PCM sample |
| pcm_r_vld | output | 1 | Right PCM strobe |
| pcm_r | output | 20 | Right PCM sample |

## Verification
The case that is hardest to reach from the ports is the boundary between frames. A legal start edge and an early one differ only by whether bit 255 is consumed on that same edge. The stimulus reaches it by raising the start line on the same launch edge as bit 255 of the previous frame, and by sending another sequence that cuts a frame short after 100 bits and then follows it with a full, fully valid frame that must be discarded. A second hard case is a strap change in the middle of a frame. A concurrent thread switches the strap 50 bits into a secondary frame, and the test then checks which slot pair was delivered.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int N_SLOTS    = 12;
  localparam int FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
  localparam int SIDX_W     = $clog2(N_SLOTS + 2);
  localparam int MODE_W     = 2;
  localparam int N_CH       = 4;

  localparam logic [MODE_W-1:0] MODE_PRI  = 2'd0;
  localparam logic [MODE_W-1:0] MODE_SEC1 = 2'd1;
  localparam logic [MODE_W-1:0] MODE_SEC2 = 2'd2;
  localparam logic [MODE_W-1:0] MODE_SEC3 = 2'd3;

  // channel order: 0 command address, 1 command data, 2 left, 3 right
  localparam int CH_CADDR = 0;
  localparam int CH_CDATA = 1;
  localparam int CH_LEFT  = 2;
  localparam int CH_RIGHT = 3;

  typedef enum logic {ST_IDLE, ST_RECV} fr_state_e;

  // slot number carrying a channel for a given codec role
  function automatic logic [SIDX_W-1:0] ch_slot(input logic [MODE_W-1:0] m, input int ch);
    logic [SIDX_W-1:0] s;
    s = '0;
    case (ch)
      CH_CADDR: s = SIDX_W'(1);
      CH_CDATA: s = SIDX_W'(2);
      CH_LEFT: begin
        case (m)
          MODE_SEC2: s = SIDX_W'(7);
          MODE_SEC3: s = SIDX_W'(6);
          default:   s = SIDX_W'(3);
        endcase
      end
      default: begin
        case (m)
          MODE_SEC2: s = SIDX_W'(8);
          MODE_SEC3: s = SIDX_W'(9);
          default:   s = SIDX_W'(4);
        endcase
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/aclink_rx_framer.sv
module aclink_rx_framer
  import aclink_rx_pkg::*;
#(
  parameter int TAG_BITS  = TAG_W,
  parameter int SLOT_BITS = SLOT_W,
  parameter int SLOTS     = N_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic              bit_stb_o,
  output logic              bit_o,
  output logic [SIDX_W-1:0] slot_o,
  output logic              start_o,
  output logic              done_o,
  output logic              abort_o
);
  localparam int LONGEST = (TAG_BITS > SLOT_BITS) ? TAG_BITS : SLOT_BITS;
  localparam int POS_W   = $clog2(LONGEST);

  fr_state_e         st_q, st_d;
  logic              sd_q, sync_q, sync_rise, in_frame, slot_end, last;
  logic [POS_W-1:0]  pos_q;
  logic [SIDX_W-1:0] slot_q;

  // serial data captured on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_i;
  end

  assign sync_rise = sync_i & ~sync_q;
  assign in_frame  = (st_q == ST_RECV);
  assign slot_end  = (slot_q == '0) ? (pos_q == POS_W'(TAG_BITS - 1))
                                    : (pos_q == POS_W'(SLOT_BITS - 1));
  assign last      = in_frame && (slot_q == SIDX_W'(SLOTS)) && slot_end;
  assign start_o   = sync_rise && (!in_frame || last);
  assign abort_o   = sync_rise && in_frame && !last;

  always_comb begin
    st_d = st_q;
    if (start_o)                 st_d = ST_RECV;
    else if (abort_o || last)    st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      slot_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        pos_q  <= '0;
        slot_q <= '0;
      end else if (in_frame) begin
        if (slot_end) begin
          pos_q  <= '0;
          slot_q <= slot_q + 1'b1;
        end else begin
          pos_q  <= pos_q + 1'b1;
        end
      end
    end
  end

  assign bit_stb_o = in_frame;
  assign bit_o     = sd_q;
  assign slot_o    = slot_q;
  assign done_o    = last;
endmodule

// File: rtl/aclink_rx_capture.sv
module aclink_rx_capture
  import aclink_rx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_stb_i,
  input  logic                         bit_i,
  input  logic [SIDX_W-1:0]            slot_i,
  input  logic                         start_i,
  input  logic [MODE_W-1:0]            strap_i,
  output logic [MODE_W-1:0]            mode_o,
  output logic [TAG_W-1:0]             tag_o,
  output logic [N_CH-1:0][SLOT_W-1:0]  ch_o
);
  logic [MODE_W-1:0] mode_q;
  logic [TAG_W-1:0]  tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_PRI;
    else if (start_i) mode_q <= strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tag_q <= '0;
    else if (bit_stb_i && slot_i == '0)  tag_q <= {tag_q[TAG_W-2:0], bit_i};
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SIDX_W-1:0] tgt;
    logic [SLOT_W-1:0] sh_q;
    assign tgt = ch_slot(mode_q, c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sh_q <= '0;
      else if (bit_stb_i && slot_i == tgt) sh_q <= {sh_q[SLOT_W-2:0], bit_i};
    end
    assign ch_o[c] = sh_q;
  end

  assign mode_o = mode_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/aclink_rx_decode.sv
module aclink_rx_decode
  import aclink_rx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         done_i,
  input  logic [MODE_W-1:0]            mode_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [N_CH-1:0][SLOT_W-1:0]  ch_i,
  output logic [N_CH-1:0]              vld_o,
  output logic [N_CH-1:0][SLOT_W-1:0]  dat_o
);
  localparam int OK_W = 1 << SIDX_W;

  logic [OK_W-1:0] slot_ok;
  logic            fv, id_hit;
  logic [N_CH-1:0] acc;

  always_comb begin
    slot_ok = '0;
    for (int s = 1; s <= N_SLOTS; s++) slot_ok[s] = tag_i[TAG_W-1-s];
  end

  assign fv     = tag_i[TAG_W-1];
  assign id_hit = (tag_i[1:0] == mode_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_acc
    logic [SIDX_W-1:0] sl;
    assign sl = ch_slot(mode_i, c);
    if (c == CH_CADDR || c == CH_CDATA) begin : g_cmd
      assign acc[c] = fv && ((mode_i == MODE_PRI) ? slot_ok[sl] : id_hit);
    end else begin : g_pcm
      assign acc[c] = fv && slot_ok[sl] && ((mode_i == MODE_PRI) || id_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_o[c] <= 1'b0;
        dat_o[c] <= '0;
      end else begin
        vld_o[c] <= done_i && acc[c];
        if (done_i && acc[c]) dat_o[c] <= ch_i[c];
      end
    end
  end
endmodule

// File: rtl/aclink_rx.sv
module aclink_rx
  import aclink_rx_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              frm_sync,
  input  logic              frm_sdata,
  input  logic [1:0]        mode_strap,
  output logic              cmd_addr_vld,
  output logic [19:0]       cmd_addr,
  output logic              cmd_data_vld,
  output logic [19:0]       cmd_data,
  output logic              pcm_l_vld,
  output logic [19:0]       pcm_l,
  output logic              pcm_r_vld,
  output logic [19:0]       pcm_r
);
  logic                        bit_stb_w, bit_w, frame_start_w, frame_done_w, frame_abort_w;
  logic [SIDX_W-1:0]           slot_w;
  logic [MODE_W-1:0]           mode_w;
  logic [TAG_W-1:0]            tag_w;
  logic [N_CH-1:0][SLOT_W-1:0] ch_w, dat_w;
  logic [N_CH-1:0]             vld_w;

  aclink_rx_framer u_framer (
    .clk(bit_clk), .rst_n(rst_n), .sync_i(frm_sync), .sdata_i(frm_sdata),
    .bit_stb_o(bit_stb_w), .bit_o(bit_w), .slot_o(slot_w),
    .start_o(frame_start_w), .done_o(frame_done_w), .abort_o(frame_abort_w)
  );

  aclink_rx_capture u_capture (
    .clk(bit_clk), .rst_n(rst_n), .bit_stb_i(bit_stb_w), .bit_i(bit_w),
    .slot_i(slot_w), .start_i(frame_start_w), .strap_i(mode_strap),
    .mode_o(mode_w), .tag_o(tag_w), .ch_o(ch_w)
  );

  aclink_rx_decode u_decode (
    .clk(bit_clk), .rst_n(rst_n), .done_i(frame_done_w), .mode_i(mode_w),
    .tag_i(tag_w), .ch_i(ch_w), .vld_o(vld_w), .dat_o(dat_w)
  );

  assign cmd_addr_vld = vld_w[CH_CADDR];
  assign cmd_addr     = dat_w[CH_CADDR];
  assign cmd_data_vld = vld_w[CH_CDATA];
  assign cmd_data     = dat_w[CH_CDATA];
  assign pcm_l_vld    = vld_w[CH_LEFT];
  assign pcm_l        = dat_w[CH_LEFT];
  assign pcm_r_vld    = vld_w[CH_RIGHT];
  assign pcm_r        = dat_w[CH_RIGHT];
endmodule

// File: rtl/aclink_rx_chk.sv
module aclink_rx_chk #(
  parameter int TAG_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic                abort,
  input logic [TAG_BITS-1:0] tag,
  input logic [1:0]          mode,
  input logic [3:0]          vld
);
  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld) |=> !(|vld));

  p_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld) |-> $past(done));

  p_abort_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !(|vld));

  p_invalid_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tag[TAG_BITS-1]) |=> !(|vld));

  p_id_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode != 2'd0 && tag[1:0] != mode) |=> !(|vld));

  p_cmd_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode != 2'd0) |=> (vld[0] == vld[1]));
endmodule

bind aclink_rx aclink_rx_chk #(.TAG_BITS(16)) u_chk (
  .clk(bit_clk), .rst_n(rst_n), .done(frame_done_w), .abort(frame_abort_w),
  .tag(tag_w), .mode(mode_w),
  .vld({pcm_r_vld, pcm_l_vld, cmd_data_vld, cmd_addr_vld})
);

// File: tb/aclink_rx_tb.sv
module aclink_rx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_sync = 1'b0;
  logic        frm_sdata = 1'b0;
  logic [1:0]  mode_strap = 2'b00;
  logic        cmd_addr_vld, cmd_data_vld, pcm_l_vld, pcm_r_vld;
  logic [19:0] cmd_addr, cmd_data, pcm_l, pcm_r;

  int n_tests = 0;
  int n_fail  = 0;
  int c_ca = 0, c_cd = 0, c_l = 0, c_r = 0;
  int b_ca, b_cd, b_l, b_r;
  logic [19:0] sl [1:12];

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  aclink_rx dut_i (
    .bit_clk(bit_clk), .rst_n(rst_n), .frm_sync(frm_sync), .frm_sdata(frm_sdata),
    .mode_strap(mode_strap),
    .cmd_addr_vld(cmd_addr_vld), .cmd_addr(cmd_addr),
    .cmd_data_vld(cmd_data_vld), .cmd_data(cmd_data),
    .pcm_l_vld(pcm_l_vld), .pcm_l(pcm_l),
    .pcm_r_vld(pcm_r_vld), .pcm_r(pcm_r)
  );

  always @(negedge bit_clk) begin
    if (rst_n) begin
      if (cmd_addr_vld) c_ca++;
      if (cmd_data_vld) c_cd++;
      if (pcm_l_vld)    c_l++;
      if (pcm_r_vld)    c_r++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tag: bit15 frame valid, bits 14..3 slot 1..12 valid (sv[11] = slot 1), bits 1:0 codec ID
  function automatic logic [15:0] mk_tag(input bit fv, input logic [11:0] sv, input logic [1:0] id);
    return {fv, sv, 1'b0, id};
  endfunction

  function automatic logic [255:0] mk_frame(input logic [15:0] tag);
    logic [255:0] fb;
    fb = '0;
    fb[255:240] = tag;
    for (int s = 1; s <= 12; s++) fb[239 - 20*(s-1) -: 20] = sl[s];
    return fb;
  endfunction

  task automatic fill_slots(input logic [19:0] seed);
    for (int s = 1; s <= 12; s++) sl[s] = seed ^ (20'h01111 * s[19:0]) ^ {s[3:0], 16'h0};
  endtask

  task automatic send_frame(input logic [255:0] fb, input bit lead, input bit chain, input int nbits);
    if (lead) begin
      @(posedge bit_clk); #1 frm_sync = 1'b1; frm_sdata = 1'b0;
    end
    for (int i = 0; i < nbits; i++) begin
      @(posedge bit_clk); #1;
      frm_sdata = fb[255 - i];
      frm_sync  = (i < 15) || (chain && i == 255);
    end
  endtask

  task automatic snap();
    b_ca = c_ca; b_cd = c_cd; b_l = c_l; b_r = c_r;
  endtask

  task automatic settle();
    repeat (4) @(negedge bit_clk);
  endtask

  task automatic exp_counts(input string req, input int ca, input int cd, input int l, input int r);
    chk((c_ca - b_ca) == ca, {req, " cmd_addr strobes"}, c_ca - b_ca, ca);
    chk((c_cd - b_cd) == cd, {req, " cmd_data strobes"}, c_cd - b_cd, cd);
    chk((c_l  - b_l)  == l,  {req, " pcm_l strobes"},    c_l - b_l, l);
    chk((c_r  - b_r)  == r,  {req, " pcm_r strobes"},    c_r - b_r, r);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge bit_clk);
    chk({cmd_addr_vld, cmd_data_vld, pcm_l_vld, pcm_r_vld} == 4'b0, "R1 strobes in reset",
        {cmd_addr_vld, cmd_data_vld, pcm_l_vld, pcm_r_vld}, 0);
    @(posedge bit_clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge bit_clk);
    chk(cmd_addr == 0 && cmd_data == 0 && pcm_l == 0 && pcm_r == 0, "R1 data after reset",
        cmd_addr ^ cmd_data ^ pcm_l ^ pcm_r, 0);
    chk({cmd_addr_vld, cmd_data_vld, pcm_l_vld, pcm_r_vld} == 4'b0, "R1 strobes after reset",
        {cmd_addr_vld, cmd_data_vld, pcm_l_vld, pcm_r_vld}, 0);
  endtask

  // R2 R3 R6: primary, all four slots valid, strobe timing
  task automatic t_primary_all();
    mode_strap = 2'b00;
    fill_slots(20'h9A5C3);
    snap();
    send_frame(mk_frame(mk_tag(1, 12'hF00, 2'b00)), 1, 0, 256);
    @(negedge bit_clk);
    chk(cmd_addr_vld == 0, "R3 no strobe before last bit consumed", cmd_addr_vld, 0);
    @(negedge bit_clk);
    chk(cmd_addr_vld && cmd_data_vld && pcm_l_vld && pcm_r_vld, "R3 strobes after last bit",
        {cmd_addr_vld, cmd_data_vld, pcm_l_vld, pcm_r_vld}, 4'hF);
    @(negedge bit_clk);
    chk(!cmd_addr_vld && !pcm_r_vld, "R3 strobe one cycle", {cmd_addr_vld, pcm_r_vld}, 0);
    chk(cmd_addr == sl[1], "R2 R6 cmd_addr slot1", cmd_addr, sl[1]);
    chk(cmd_data == sl[2], "R2 R6 cmd_data slot2", cmd_data, sl[2]);
    chk(pcm_l == sl[3], "R2 R6 pcm_l slot3", pcm_l, sl[3]);
    chk(pcm_r == sl[4], "R2 R6 pcm_r slot4", pcm_r, sl[4]);
    settle();
    exp_counts("R3", 1, 1, 1, 1);
  endtask

  // R6: per-slot valid bits, ID ignored in primary; R3: unstrobed data holds
  task automatic t_primary_partial();
    logic [19:0] old_cd, old_l;
    old_cd = cmd_data; old_l = pcm_l;
    mode_strap = 2'b00;
    fill_slots(20'h13579);
    snap();
    send_frame(mk_frame(mk_tag(1, 12'b1001_0000_0000, 2'b11)), 1, 0, 256);
    settle();
    exp_counts("R6", 1, 0, 0, 1);
    chk(cmd_addr == sl[1], "R6 cmd_addr", cmd_addr, sl[1]);
    chk(pcm_r == sl[4], "R6 pcm_r", pcm_r, sl[4]);
    chk(cmd_data == old_cd, "R3 cmd_data held", cmd_data, old_cd);
    chk(pcm_l == old_l, "R3 pcm_l held", pcm_l, old_l);
  endtask

  task automatic t_frame_invalid();
    mode_strap = 2'b00;
    fill_slots(20'h0F0F0);
    snap();
    send_frame(mk_frame(mk_tag(0, 12'hFFF, 2'b00)), 1, 0, 256);
    settle();
    exp_counts("R5", 0, 0, 0, 0);
  endtask

  task automatic t_abort();
    logic [255:0] good;
    mode_strap = 2'b00;
    fill_slots(20'h55AA5);
    snap();
    send_frame(mk_frame(mk_tag(1, 12'hFFF, 2'b00)), 1, 0, 100);
    fill_slots(20'hAAAAA);
    send_frame(mk_frame(mk_tag(1, 12'hFFF, 2'b00)), 1, 0, 256);
    settle();
    exp_counts("R4 cut and ignored frames", 0, 0, 0, 0);
    fill_slots(20'h3C3C3);
    good = mk_frame(mk_tag(1, 12'hF00, 2'b00));
    snap();
    send_frame(good, 1, 0, 256);
    settle();
    exp_counts("R4 recovery", 1, 1, 1, 1);
    chk(pcm_l == sl[3], "R4 recovered pcm_l", pcm_l, sl[3]);
  endtask

  // R8 R9: secondary, cmd via ID only (tag 14/13 clear)
  task automatic t_secondary(input logic [1:0] m, input int ls, input int rs, input bit rvalid);
    logic [11:0] sv;
    logic [19:0] old_r;
    old_r = pcm_r;
    mode_strap = m;
    fill_slots(20'h70000 ^ {18'h0, m});
    sv = '0;
    sv[12 - ls] = 1'b1;
    if (rvalid) sv[12 - rs] = 1'b1;
    snap();
    send_frame(mk_frame(mk_tag(1, sv, m)), 1, 0, 256);
    settle();
    exp_counts(rvalid ? "R8 R9 secondary" : "R9 secondary right invalid", 1, 1, 1, rvalid ? 1 : 0);
    chk(cmd_addr == sl[1], "R8 cmd_addr", cmd_addr, sl[1]);
    chk(cmd_data == sl[2], "R8 cmd_data", cmd_data, sl[2]);
    chk(pcm_l == sl[ls], "R9 pcm_l slot map", pcm_l, sl[ls]);
    if (rvalid) chk(pcm_r == sl[rs], "R9 pcm_r slot map", pcm_r, sl[rs]);
    else        chk(pcm_r == old_r, "R9 pcm_r held", pcm_r, old_r);
  endtask

  task automatic t_sec_mismatch();
    mode_strap = 2'b10;
    fill_slots(20'h11111);
    snap();
    send_frame(mk_frame(mk_tag(1, 12'hFFF, 2'b01)), 1, 0, 256);
    settle();
    exp_counts("R7", 0, 0, 0, 0);
  endtask

  task automatic t_back_to_back();
    mode_strap = 2'b00;
    fill_slots(20'h24680);
    snap();
    send_frame(mk_frame(mk_tag(1, 12'hF00, 2'b00)), 1, 1, 256);
    fill_slots(20'h86420);
    send_frame(mk_frame(mk_tag(1, 12'hF00, 2'b00)), 0, 0, 256);
    settle();
    exp_counts("R10", 2, 2, 2, 2);
    chk(pcm_r == sl[4], "R10 second frame pcm_r", pcm_r, sl[4]);
  endtask

  task automatic t_strap_midframe();
    fill_slots(20'h5E5E5);
    mode_strap = 2'b01;
    snap();
    fork
      send_frame(mk_frame(mk_tag(1, 12'b0011_1100_0000, 2'b01)), 1, 0, 256);
      begin
        repeat (50) @(posedge bit_clk);
        #2 mode_strap = 2'b10;
      end
    join
    settle();
    exp_counts("R11", 1, 1, 1, 1);
    chk(pcm_l == sl[3], "R11 pcm_l from latched mode", pcm_l, sl[3]);
    chk(pcm_r == sl[4], "R11 pcm_r from latched mode", pcm_r, sl[4]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_primary_all();
    t_primary_partial();
    t_frame_invalid();
    t_abort();
    t_secondary(2'b01, 3, 4, 1);
    t_secondary(2'b10, 7, 8, 1);
    t_secondary(2'b11, 6, 9, 1);
    t_secondary(2'b11, 6, 9, 0);
    t_sec_mismatch();
    t_back_to_back();
    t_strap_midframe();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule